// File: doc/BRIEF.md
# Completion Ring Entry Writer

This block is the DMA-side producer for a ring of completion records kept in host memory. Each time the packet logic reports a finished packet, it supplies a descriptor pointer, a channel number and a three-bit status. The block packs these into one 32-bit record and issues a single memory write at the slot that its producer index selects. Once the memory port accepts the write, the producer index moves on by one. It returns to zero after the programmable last slot index.

The host owns the consumer index. It reads records and then stores the new consumer index through a one-cycle write strobe. From the two indices and the last slot index, the block derives the number of records waiting and a full condition. When the ring is full, a new completion is held at the input and a stall flag is raised until the host frees a slot.

Top module: `dq_ring_writer`

## Requirements
- R1: The record on `mem_data` holds the descriptor pointer in bits 15..0, the channel in bits 23..16 and the status in bits 28..26. Bits 25..24 and 31..29 are zero. A status of 0 means the packet completed.
- R2: `mem_addr` equals `ring_base` plus four times the producer index at which the record is written.
- R3: The producer index changes only in the cycle after a memory handshake (`mem_valid` and `mem_ready` both high), and then it grows by one. While `mem_ready` is low, the index is held.
- R4: A handshake taken at producer index equal to `ring_last` returns the producer index to 0.
- R5: A cycle with `host_rd_we` high loads `host_rd_val` into the consumer index, visible on `rd_ptr` one cycle later.
- R6: `occupancy` is wr_ptr − rd_ptr when wr_ptr ≥ rd_ptr. Otherwise it is ring_last + 1 − rd_ptr + wr_ptr.
- R7: `full` is high when the next producer index would equal the consumer index. While full, `cmp_ready` is low and a completion waits. `stall` is high whenever `cmp_valid` is waiting in that state.
- R8: Only one write is outstanding. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold, and `cmp_ready` is low.
- R9: After reset, both indices and `occupancy` are 0, `mem_valid` is low and `cmp_ready` is high.
- R10: A completion accepted at a clock edge (`cmp_valid` and `cmp_ready` high) shows `mem_valid` high in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 32 | Byte address of ring slot 0 |
| ring_last | input | 16 | Index of the last ring slot |
| cmp_valid | input | 1 | Completion offered |
| cmp_ready | output | 1 | Completion accepted this cycle |
| cmp_desc | input | 16 | Descriptor pointer of finished packet |
| cmp_chan | input | 8 | Channel number |
| cmp_stat | input | 3 | Packet status code |
| host_rd_we | input | 1 | Host stores a new consumer index |
| host_rd_val | input | 16 | New consumer index |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Write byte address |
| mem_data | output | 32 | Completion record |
| wr_ptr | output | 16 | Producer index |
| rd_ptr | output | 16 | Consumer index |
| occupancy | output | 17 | Records waiting for the host |
| full | output | 1 | No free slot |
| stall | output | 1 | Completion held because the ring is full |

## Verification
The bench drives inputs on the falling edge and samples on the next falling edge. Each expectation therefore falls one rising edge after its cause.

- **Write request:** `mem_valid`, the address and the record are checked in the first sample after acceptance.
- **Held request:** they are checked again at each sample while `mem_ready` stays low, with the producer index unchanged.
- **Producer index:** its new value is checked in the sample after the handshake edge. `occupancy` and `full` are combinational, so they are checked in that same sample.
- **Consumer index:** a host store is checked one sample after its strobe.
- **Full ring:** the stall flag and the low ready are checked at once, because both are combinational.

// File: rtl/dq_ring_pkg.sv
package dq_ring_pkg;

    localparam int PTR_W    = 16;
    localparam int DESC_W   = 16;
    localparam int CHAN_W   = 8;
    localparam int STAT_W   = 3;
    localparam int ADDR_W   = 32;
    localparam int ENTRY_W  = 32;
    localparam int SLOT_SH  = 2;   // 4-byte slots
    localparam int DESC_LSB = 0;
    localparam int CHAN_LSB = 16;
    localparam int STAT_LSB = 26;

    typedef logic [PTR_W-1:0]   ptr_t;
    typedef logic [PTR_W:0]     cnt_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [ENTRY_W-1:0] entry_t;

    typedef struct packed {
        logic [DESC_W-1:0] desc;
        logic [CHAN_W-1:0] chan;
        logic [STAT_W-1:0] stat;
    } done_t;

    typedef enum logic [0:0] {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_state_e;

    function automatic ptr_t ptr_step(input ptr_t p, input ptr_t last);
        return (p == last) ? '0 : ptr_t'(p + 1'b1);
    endfunction

    function automatic cnt_t ring_count(input ptr_t w, input ptr_t r, input ptr_t last);
        if (w >= r)
            return cnt_t'({1'b0, w}) - cnt_t'({1'b0, r});
        else
            return cnt_t'({1'b0, last}) + cnt_t'(1) - cnt_t'({1'b0, r}) + cnt_t'({1'b0, w});
    endfunction

    function automatic entry_t pack_entry(input done_t d);
        entry_t e;
        e = '0;
        e[DESC_LSB +: DESC_W] = d.desc;
        e[CHAN_LSB +: CHAN_W] = d.chan;
        e[STAT_LSB +: STAT_W] = d.stat;
        return e;
    endfunction

endpackage

// File: rtl/dq_entry_fmt.sv
module dq_entry_fmt
    import dq_ring_pkg::*;
(
    input  done_t  done_in,
    output entry_t entry
);
    always_comb entry = pack_entry(done_in);
endmodule

// File: rtl/dq_ptr_ring.sv
module dq_ptr_ring
    import dq_ring_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic host_we,
    input  ptr_t host_val,
    input  ptr_t last,
    output ptr_t wr_ptr,
    output ptr_t rd_ptr,
    output cnt_t count,
    output logic full
);
    ptr_t wr_q, rd_q, wr_next;

    always_comb wr_next = ptr_step(wr_q, last);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (advance) wr_q <= wr_next;
            if (host_we) rd_q <= host_val;
        end
    end

    always_comb begin
        wr_ptr = wr_q;
        rd_ptr = rd_q;
        count  = ring_count(wr_q, rd_q, last);
        full   = (wr_next == rd_q);
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(wr_ptr));                                   // R3
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (advance && wr_ptr == last) |=> (wr_ptr == '0));                 // R4
    AST_HOST_LOAD: assert property (@(posedge clk) disable iff (rst)
        host_we |=> (rd_ptr == $past(host_val)));                        // R5
    AST_FULL_COUNT: assert property (@(posedge clk) disable iff (rst)
        full |-> (count == cnt_t'({1'b0, last})));                       // R6
endmodule

// File: rtl/dq_wr_ctrl.sv
module dq_wr_ctrl
    import dq_ring_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cmp_valid,
    output logic   cmp_ready,
    input  entry_t entry,
    input  addr_t  slot_addr,
    input  logic   full,
    output logic   mem_valid,
    input  logic   mem_ready,
    output addr_t  mem_addr,
    output entry_t mem_data,
    output logic   advance,
    output logic   stall
);
    wr_state_e state;
    addr_t     addr_q;
    entry_t    data_q;

    always_comb begin
        cmp_ready = (state == WR_IDLE) && !full;
        stall     = (state == WR_IDLE) && full && cmp_valid;
        mem_valid = (state == WR_BUSY);
        advance   = (state == WR_BUSY) && mem_ready;
        mem_addr  = addr_q;
        mem_data  = data_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WR_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            unique case (state)
                WR_IDLE: if (cmp_valid && cmp_ready) begin
                    addr_q <= slot_addr;
                    data_q <= entry;
                    state  <= WR_BUSY;
                end
                WR_BUSY: if (mem_ready) state <= WR_IDLE;
                default: state <= WR_IDLE;
            endcase
        end
    end

    AST_ACCEPT_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_ready) |=> mem_valid);                         // R10
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R8
endmodule

// File: rtl/dq_ring_writer.sv
module dq_ring_writer
    import dq_ring_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   ring_base,
    input  logic [PTR_W-1:0]    ring_last,
    input  logic                cmp_valid,
    output logic                cmp_ready,
    input  logic [DESC_W-1:0]   cmp_desc,
    input  logic [CHAN_W-1:0]   cmp_chan,
    input  logic [STAT_W-1:0]   cmp_stat,
    input  logic                host_rd_we,
    input  logic [PTR_W-1:0]    host_rd_val,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [ENTRY_W-1:0]  mem_data,
    output logic [PTR_W-1:0]    wr_ptr,
    output logic [PTR_W-1:0]    rd_ptr,
    output logic [PTR_W:0]      occupancy,
    output logic                full,
    output logic                stall
);
    done_t  done_in;
    entry_t entry;
    addr_t  slot_addr;
    logic   advance;

    always_comb begin
        done_in.desc = cmp_desc;
        done_in.chan = cmp_chan;
        done_in.stat = cmp_stat;
        slot_addr    = ring_base + addr_t'({wr_ptr, {SLOT_SH{1'b0}}});
    end

    dq_entry_fmt u_fmt (
        .done_in (done_in),
        .entry   (entry)
    );

    dq_ptr_ring u_ptr (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .host_we  (host_rd_we),
        .host_val (host_rd_val),
        .last     (ring_last),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (occupancy),
        .full     (full)
    );

    dq_wr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmp_valid (cmp_valid),
        .cmp_ready (cmp_ready),
        .entry     (entry),
        .slot_addr (slot_addr),
        .full      (full),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .advance   (advance),
        .stall     (stall)
    );

    AST_RECORD_PAD: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_data[25:24] == 2'b00 && mem_data[31:29] == 3'b000)); // R1
    AST_SLOT_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> ((mem_addr - ring_base) == addr_t'({wr_ptr, 2'b00})));    // R2
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        full |-> !cmp_ready);                                                   // R7
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !cmp_ready);                                              // R8
endmodule

// File: tb/tb_dq_ring_writer.sv
module tb_dq_ring_writer;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ring_base;
    logic [15:0] ring_last;
    logic        cmp_valid, cmp_ready;
    logic [15:0] cmp_desc;
    logic [7:0]  cmp_chan;
    logic [2:0]  cmp_stat;
    logic        host_rd_we;
    logic [15:0] host_rd_val;
    logic        mem_valid, mem_ready;
    logic [31:0] mem_addr, mem_data;
    logic [15:0] wr_ptr, rd_ptr;
    logic [16:0] occupancy;
    logic        full, stall;

    always #4 clk = ~clk;

    dq_ring_writer dut (.*);

    int checks = 0;
    int errors = 0;
    int exp_wr = 0;
    int exp_rd = 0;

    // {desc, chan, stat, ready delay, host consumes afterwards}
    localparam int NV = 8;
    localparam logic [31:0] VEC [NV] = '{
        {16'h0000, 8'h03, 3'd0, 4'd0, 1'b0},
        {16'hBEEF, 8'hFF, 3'd7, 4'd2, 1'b1},
        {16'h1234, 8'h00, 3'd5, 4'd0, 1'b0},
        {16'hFFFF, 8'h5A, 3'd1, 4'd3, 1'b0},
        {16'h0F0F, 8'hA5, 3'd2, 4'd1, 1'b1},
        {16'h8001, 8'h7E, 3'd0, 4'd0, 1'b0},
        {16'h4444, 8'h11, 3'd4, 4'd4, 1'b1},
        {16'h0002, 8'h80, 3'd6, 4'd0, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int exp_occ(input int w, input int r, input int last);
        return (w >= r) ? (w - r) : (last + 1 - r + w);
    endfunction

    function automatic int step(input int p);
        return (p == int'(ring_last)) ? 0 : p + 1;
    endfunction

    task automatic host_store(input int v);
        @(negedge clk);
        host_rd_we = 1'b1; host_rd_val = 16'(v);
        @(negedge clk);
        host_rd_we = 1'b0;
        exp_rd = v;
        chk(rd_ptr == 16'(v), "R5 consumer index load", rd_ptr, v);
    endtask

    task automatic do_write(input logic [15:0] d, input logic [7:0] c, input logic [2:0] s, input int dly);
        logic [31:0] rec;
        logic [31:0] adr;
        rec = {3'b000, s, 2'b00, c, d};
        adr = ring_base + 32'(exp_wr * 4);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_desc = d; cmp_chan = c; cmp_stat = s;
        #1;
        chk(cmp_ready == 1'b1, "R7 ready when not full", cmp_ready, 1);
        @(negedge clk);
        cmp_valid = 1'b0;
        chk(mem_valid == 1'b1, "R10 request next cycle", mem_valid, 1);
        chk(mem_data == rec, "R1 record layout", mem_data, rec);
        chk(mem_addr == adr, "R2 slot address", mem_addr, adr);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk(mem_valid && mem_addr == adr && mem_data == rec && !cmp_ready,
                "R8 request held", {mem_valid, mem_addr}, {1'b1, adr});
            chk(wr_ptr == 16'(exp_wr), "R3 index held while not ready", wr_ptr, exp_wr);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        exp_wr = step(exp_wr);
        chk(mem_valid == 1'b0, "R8 request drops after handshake", mem_valid, 0);
        chk(wr_ptr == 16'(exp_wr), "R3 R4 index advance", wr_ptr, exp_wr);
        chk(occupancy == 17'(exp_occ(exp_wr, exp_rd, int'(ring_last))), "R6 occupancy",
            occupancy, exp_occ(exp_wr, exp_rd, int'(ring_last)));
    endtask

    task automatic do_reset(input logic [15:0] last);
        rst = 1'b1; ring_last = last;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_wr = 0; exp_rd = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cmp_valid = 0; cmp_desc = 0; cmp_chan = 0; cmp_stat = 0;
        host_rd_we = 0; host_rd_val = 0; mem_ready = 0;
        ring_base = 32'h1000_0000;
        do_reset(16'd5);

        // R9 reset state
        chk(wr_ptr == 0 && rd_ptr == 0, "R9 indices after reset", {wr_ptr, rd_ptr}, 0);
        chk(occupancy == 0, "R9 occupancy after reset", occupancy, 0);
        chk(mem_valid == 0 && cmp_ready == 1, "R9 port state after reset", {mem_valid, cmp_ready}, 2'b01);

        // vector walk: 8 writes around a 6-slot ring (wraps once, R4)
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][31:16], VEC[i][15:8], VEC[i][7:5], int'(VEC[i][4:1]));
            if (VEC[i][0]) host_store(exp_wr);
        end

        // full ring: 4 slots, consumer at 0
        ring_base = 32'h0000_2000;
        do_reset(16'd3);
        for (int i = 0; i < 3; i++) do_write(16'(i + 1), 8'h09, 3'd0, 0);
        chk(full == 1'b1, "R7 full when next equals consumer", full, 1);
        chk(occupancy == 3, "R6 occupancy at full", occupancy, 3);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_desc = 16'h00AA; cmp_chan = 8'h09; cmp_stat = 3'd0;
        #1;
        chk(cmp_ready == 0 && stall == 1, "R7 stall and no ready while full", {cmp_ready, stall}, 2'b01);
        repeat (2) @(negedge clk);
        chk(mem_valid == 0 && stall == 1, "R7 completion held", {mem_valid, stall}, 2'b01);
        chk(wr_ptr == 3, "R3 no advance while full", wr_ptr, 3);
        // host frees two slots; the held completion is then taken at slot 3
        host_rd_we = 1'b1; host_rd_val = 16'd2;
        @(negedge clk);
        host_rd_we = 1'b0; exp_rd = 2;
        chk(rd_ptr == 2, "R5 consumer index load", rd_ptr, 2);
        #1;
        chk(full == 0 && cmp_ready == 1 && stall == 0, "R7 full clears", {full, cmp_ready, stall}, 3'b010);
        @(negedge clk);
        cmp_valid = 1'b0;
        chk(mem_valid == 1, "R10 held completion issued", mem_valid, 1);
        chk(mem_addr == 32'h0000_200C, "R2 last slot address", mem_addr, 32'h0000_200C);
        chk(mem_data == 32'h0009_00AA, "R1 record after hold", mem_data, 32'h0009_00AA);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        chk(wr_ptr == 0, "R4 wrap at last slot", wr_ptr, 0);
        chk(occupancy == 2, "R6 occupancy with wrapped producer", occupancy, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule